// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps a set of packet queues whose entries are descriptor addresses. All queues share a single link RAM, and each queue is a singly linked list threaded through it. Each queue keeps only a head index, a tail index and an entry count. A descriptor address is turned into a link index through fixed region entries. Each region has a base address, a descriptor count, a descriptor size (a power of two, given as a shift) and the link index of its first slot. The index is the start index plus (address − base) >> shift. On a pop, the same entries map the index back to the address.

A push enqueues a descriptor address onto a numbered queue. A pop request names a queue, and one cycle later the response returns the dequeued address. The instance owns `NUM_Q` queues, numbered `QBASE` to `QBASE+NUM_Q-1`. A combinational peek port reports the entry count of any queue number without changing anything. A per-queue non-empty vector can drive level interrupts. Bad pushes are dropped and raise a sticky error flag.

Both request channels are valid/ready, and a transfer happens on a clock edge where valid and ready are both high. The push channel never applies back-pressure. The pop channel drops `pop_ready` while a push to the same queue number is presented. The push then completes first, and the held pop is accepted on a later cycle. The pop response is a one-cycle `pop_rsp_valid` pulse with no ready, so the consumer must take it in that cycle.

Top module: `desc_queue_mgr`

## Requirements
- R1: A push to an owned queue with an address inside a region, aligned to that region's descriptor size, raises that queue's count by one, as seen on the peek port after the accepting edge.
- R2: With the default parameters there are two regions. Region 0 has base 0x1000_0000, 16 slots of 64 bytes and start index 0. Region 1 has base 0x2000_0000, 32 slots of 128 bytes and start index 16. Any slot of either region, including the last slot, is accepted, and popping it returns the same address.
- R3: Pops return each queue's descriptors in push order. `pop_rsp_valid` is high in the cycle after an accepted pop, with the address on `pop_rsp_addr`, and the count drops by one.
- R4: Queues are independent even though they share link RAM: interleaved pushes to different queues pop back per queue in order.
- R5: An accepted pop of an empty or unowned queue gives `pop_rsp_valid`=1 with address 0 and changes no count.
- R6: A push to an unowned queue number, to an address outside every region, or to an address not aligned to the region's descriptor size is dropped. It sets `err_flag`, which stays set until reset.
- R7: When push and pop name the same queue in one cycle, `pop_ready` is 0 and the push completes. The held pop is accepted in the next cycle and returns the pushed address.
- R8: `peek_count`/`peek_nonempty` show the count of `peek_qnum` combinationally, and 0 for an unowned number.
- R9: Bit i of `q_nonempty` is 1 exactly when queue `QBASE+i` holds at least one entry.
- R10: After reset all queues are empty, `err_flag`=0, `pop_rsp_valid`=0, and `push_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push request present |
| push_ready | output | 1 | Push accepted (always 1) |
| push_qnum | input | QN_W | Target queue number |
| push_addr | input | ADDR_W | Descriptor address to enqueue |
| pop_valid | input | 1 | Pop request present |
| pop_ready | output | 1 | Pop accepted this cycle |
| pop_qnum | input | QN_W | Queue number to dequeue |
| pop_rsp_valid | output | 1 | One-cycle pulse after an accepted pop |
| pop_rsp_addr | output | ADDR_W | Dequeued address, 0 when nothing was dequeued |
| peek_qnum | input | QN_W | Queue number to inspect |
| peek_count | output | CNT_W | Entry count of `peek_qnum` |
| peek_nonempty | output | 1 | `peek_count` is nonzero |
| q_nonempty | output | NUM_Q | Level non-empty flag per owned queue |
| err_flag | output | 1 | Sticky dropped-push indicator |

## Verification
The bench covers the following cases:

- **Region edges.** It pushes the last slot of each region, a misaligned address, and the first address past each region. A mapper with an off-by-one limit or a missing alignment check would accept a bad address or reject a good one.
- **Same-queue collision.** A design that let the pop win would report the queue empty and return zero. One that served both at once would corrupt the head or the count.
- **Long shared-RAM list.** It fills one queue with sixteen descriptors while another queue is live, then drains it. Broken tail linking shows up there as a wrong order.
- **Empty and unowned pops.** These must return zero with the counts intact.
- **Sticky error.** `err_flag` must stay set across later good pushes.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
  localparam int RGN_FW = 16;  // width of count/start fields per region
  localparam int RGN_SW = 5;   // width of size shift field per region

  function automatic logic in_window(int v, int lo, int n);
    return (v >= lo) && (v < lo + n);
  endfunction
endpackage

// File: rtl/dqm_region_map.sv
module dqm_region_map #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int NUM_RGN = 2,
  parameter logic [NUM_RGN*ADDR_W-1:0]         RGN_BASE  = '0,
  parameter logic [NUM_RGN*dqm_pkg::RGN_FW-1:0] RGN_CNT   = '0,
  parameter logic [NUM_RGN*dqm_pkg::RGN_SW-1:0] RGN_SHIFT = '0,
  parameter logic [NUM_RGN*dqm_pkg::RGN_FW-1:0] RGN_START = '0
) (
  input  logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_hit,
  output logic [IDX_W-1:0]  fwd_idx,
  input  logic [IDX_W-1:0]  rev_idx,
  output logic [ADDR_W-1:0] rev_addr
);
  localparam int FW = dqm_pkg::RGN_FW;
  localparam int SW = dqm_pkg::RGN_SW;

  logic [NUM_RGN-1:0] hit_v, rhit_v;
  logic [IDX_W-1:0]   idx_v  [NUM_RGN];
  logic [ADDR_W-1:0]  raddr_v[NUM_RGN];

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    localparam logic [ADDR_W-1:0] BASE  = RGN_BASE[r*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] CNT   = ADDR_W'(RGN_CNT[r*FW +: FW]);
    localparam logic [ADDR_W-1:0] START = ADDR_W'(RGN_START[r*FW +: FW]);
    localparam int                SH    = int'(RGN_SHIFT[r*SW +: SW]);
    localparam logic [ADDR_W-1:0] MASK  = (ADDR_W'(1) << SH) - ADDR_W'(1);

    logic [ADDR_W-1:0] off, slot, ridx, rel;
    assign off  = fwd_addr - BASE;
    assign slot = off >> SH;
    assign hit_v[r] = (fwd_addr >= BASE) && (slot < CNT) && ((off & MASK) == '0);
    assign idx_v[r] = IDX_W'(START + slot);

    assign ridx = ADDR_W'(rev_idx);
    assign rel  = ridx - START;
    assign rhit_v[r]  = (ridx >= START) && (rel < CNT);
    assign raddr_v[r] = BASE + (rel << SH);
  end

  // lowest-numbered region wins on overlap
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_idx  = '0;
    rev_addr = '0;
    for (int r = NUM_RGN - 1; r >= 0; r--) begin
      if (hit_v[r]) begin
        fwd_hit = 1'b1;
        fwd_idx = idx_v[r];
      end
      if (rhit_v[r]) rev_addr = raddr_v[r];
    end
  end
endmodule

// File: rtl/dqm_link_ram.sv
module dqm_link_ram #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [IDX_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [IDX_W-1:0] rdata
);
  logic [IDX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dqm_queue_table.sv
module dqm_queue_table #(
  parameter int NUM_Q      = 4,
  parameter int QI_W       = 2,
  parameter int IDX_W      = 6,
  parameter int CNT_W      = 7,
  parameter int LINK_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [QI_W-1:0]  push_q,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop_en,
  input  logic [QI_W-1:0]  pop_q,
  input  logic [IDX_W-1:0] link_next,
  output logic [IDX_W-1:0] pop_head,
  output logic             link_we,
  output logic [IDX_W-1:0] link_waddr,
  output logic [IDX_W-1:0] link_wdata,
  output logic [CNT_W-1:0] cnt_o [NUM_Q]
);
  logic [IDX_W-1:0] head_q [NUM_Q];
  logic [IDX_W-1:0] tail_q [NUM_Q];
  logic [CNT_W-1:0] cnt_q  [NUM_Q];

  // push and pop never target the same queue in one cycle (top stalls pop)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) begin
        head_q[i] <= '0;
        tail_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_Q; i++) begin
        if (push_en && push_q == QI_W'(i)) begin
          if (cnt_q[i] == '0) head_q[i] <= push_idx;
          tail_q[i] <= push_idx;
          cnt_q[i]  <= cnt_q[i] + CNT_W'(1);
        end else if (pop_en && pop_q == QI_W'(i)) begin
          head_q[i] <= link_next;
          cnt_q[i]  <= cnt_q[i] - CNT_W'(1);
        end
      end
    end
  end

  assign pop_head   = head_q[pop_q];
  assign link_we    = push_en && (cnt_q[push_q] != '0);
  assign link_waddr = tail_q[push_q];
  assign link_wdata = push_idx;

  for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_out
    assign cnt_o[gi] = cnt_q[gi];

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[gi] <= CNT_W'(LINK_DEPTH));

    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_q[gi]) |-> (cnt_q[gi] == $past(cnt_q[gi]) + CNT_W'(1)) ||
                              (cnt_q[gi] == $past(cnt_q[gi]) - CNT_W'(1)));
  end
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr #(
  parameter int QN_W       = 12,
  parameter int QBASE      = 100,
  parameter int NUM_Q      = 4,
  parameter int ADDR_W     = 32,
  parameter int LINK_DEPTH = 64,
  parameter int NUM_RGN    = 2,
  parameter logic [NUM_RGN*ADDR_W-1:0]          RGN_BASE  = {32'h2000_0000, 32'h1000_0000},
  parameter logic [NUM_RGN*dqm_pkg::RGN_FW-1:0] RGN_CNT   = {16'd32, 16'd16},
  parameter logic [NUM_RGN*dqm_pkg::RGN_SW-1:0] RGN_SHIFT = {5'd7, 5'd6},
  parameter logic [NUM_RGN*dqm_pkg::RGN_FW-1:0] RGN_START = {16'd16, 16'd0},
  localparam int IDX_W = $clog2(LINK_DEPTH),
  localparam int CNT_W = $clog2(LINK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [QN_W-1:0]   push_qnum,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop_valid,
  output logic              pop_ready,
  input  logic [QN_W-1:0]   pop_qnum,
  output logic              pop_rsp_valid,
  output logic [ADDR_W-1:0] pop_rsp_addr,
  input  logic [QN_W-1:0]   peek_qnum,
  output logic [CNT_W-1:0]  peek_count,
  output logic              peek_nonempty,
  output logic [NUM_Q-1:0]  q_nonempty,
  output logic              err_flag
);
  localparam int QI_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic             push_own, pop_own, peek_own;
  logic [QI_W-1:0]  push_li, pop_li, peek_li;
  logic             fwd_hit, push_en, pop_fire, pop_has, pop_en, push_bad;
  logic [IDX_W-1:0] fwd_idx, pop_head, link_next, link_waddr, link_wdata;
  logic             link_we;
  logic [ADDR_W-1:0] rev_addr;
  logic [CNT_W-1:0] cnt_w [NUM_Q];

  assign push_own = dqm_pkg::in_window(int'(push_qnum), QBASE, NUM_Q);
  assign pop_own  = dqm_pkg::in_window(int'(pop_qnum),  QBASE, NUM_Q);
  assign peek_own = dqm_pkg::in_window(int'(peek_qnum), QBASE, NUM_Q);
  assign push_li  = QI_W'(push_qnum - QN_W'(QBASE));
  assign pop_li   = QI_W'(pop_qnum  - QN_W'(QBASE));
  assign peek_li  = QI_W'(peek_qnum - QN_W'(QBASE));

  // push never stalls; pop yields to a push of the same queue number
  assign push_ready = 1'b1;
  assign pop_ready  = !(push_valid && push_qnum == pop_qnum);

  assign push_en  = push_valid && push_own && fwd_hit;
  assign push_bad = push_valid && !(push_own && fwd_hit);
  assign pop_fire = pop_valid && pop_ready;
  assign pop_has  = pop_own && (cnt_w[pop_li] != '0);
  assign pop_en   = pop_fire && pop_has;

  dqm_region_map #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_RGN(NUM_RGN),
    .RGN_BASE(RGN_BASE), .RGN_CNT(RGN_CNT), .RGN_SHIFT(RGN_SHIFT), .RGN_START(RGN_START)
  ) u_map (
    .fwd_addr(push_addr), .fwd_hit(fwd_hit), .fwd_idx(fwd_idx),
    .rev_idx(pop_head), .rev_addr(rev_addr)
  );

  dqm_link_ram #(.DEPTH(LINK_DEPTH), .IDX_W(IDX_W)) u_link (
    .clk(clk), .we(link_we), .waddr(link_waddr), .wdata(link_wdata),
    .raddr(pop_head), .rdata(link_next)
  );

  dqm_queue_table #(
    .NUM_Q(NUM_Q), .QI_W(QI_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .LINK_DEPTH(LINK_DEPTH)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_en), .push_q(push_li), .push_idx(fwd_idx),
    .pop_en(pop_en), .pop_q(pop_li), .link_next(link_next),
    .pop_head(pop_head), .link_we(link_we), .link_waddr(link_waddr),
    .link_wdata(link_wdata), .cnt_o(cnt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_rsp_valid <= 1'b0;
      pop_rsp_addr  <= '0;
      err_flag      <= 1'b0;
    end else begin
      pop_rsp_valid <= pop_fire;
      pop_rsp_addr  <= pop_en ? rev_addr : '0;
      if (push_bad) err_flag <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_ne
    assign q_nonempty[i] = (cnt_w[i] != '0);
  end

  assign peek_count    = peek_own ? cnt_w[peek_li] : '0;
  assign peek_nonempty = (peek_count != '0);

  assert_rsp_follows_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_rsp_valid |-> $past(pop_valid && pop_ready));

  assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !pop_has) |=> (pop_rsp_addr == '0));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_same_q_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_valid && push_qnum == pop_qnum) |=> !pop_rsp_valid);
endmodule

// File: tb/sim_desc_queue_mgr.sv
module sim_desc_queue_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0, pop_valid = 1'b0;
  logic [11:0] push_qnum = '0, pop_qnum = '0, peek_qnum = '0;
  logic [31:0] push_addr = '0;
  logic        push_ready, pop_ready, pop_rsp_valid, peek_nonempty, err_flag;
  logic [31:0] pop_rsp_addr;
  logic [6:0]  peek_count;
  logic [3:0]  q_nonempty;

  int n_run = 0, n_fail = 0;
  int exp_cnt [4];
  bit done = 0;

  always #5 clk = ~clk;

  desc_queue_mgr u0 (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_qnum(push_qnum), .push_addr(push_addr),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_qnum(pop_qnum),
    .pop_rsp_valid(pop_rsp_valid), .pop_rsp_addr(pop_rsp_addr),
    .peek_qnum(peek_qnum), .peek_count(peek_count), .peek_nonempty(peek_nonempty),
    .q_nonempty(q_nonempty), .err_flag(err_flag)
  );

  typedef struct packed {
    logic        is_pop;
    logic [11:0] q;
    logic [31:0] arg;   // push: address; pop: expected response
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'd100, 32'h1000_0000},
    '{1'b0, 12'd100, 32'h2000_0080},
    '{1'b0, 12'd101, 32'h1000_0040},
    '{1'b0, 12'd100, 32'h1000_03C0},
    '{1'b0, 12'd103, 32'h2000_0F80},
    '{1'b1, 12'd100, 32'h1000_0000},
    '{1'b1, 12'd101, 32'h1000_0040},
    '{1'b1, 12'd100, 32'h2000_0080},
    '{1'b0, 12'd101, 32'h2000_0000},
    '{1'b1, 12'd100, 32'h1000_03C0},
    '{1'b1, 12'd100, 32'h0000_0000},
    '{1'b1, 12'd103, 32'h2000_0F80},
    '{1'b1, 12'd101, 32'h2000_0000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push_valid = 1'b0; pop_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
  endtask

  task automatic do_push(logic [11:0] q, logic [31:0] a);
    @(negedge clk);
    push_valid = 1'b1; push_qnum = q; push_addr = a;
    @(posedge clk); #1;
    push_valid = 1'b0;
  endtask

  task automatic do_pop(logic [11:0] q, output logic v, output logic [31:0] a);
    @(negedge clk);
    pop_valid = 1'b1; pop_qnum = q;
    @(posedge clk); #1;
    pop_valid = 1'b0;
    v = pop_rsp_valid; a = pop_rsp_addr;
  endtask

  task automatic peek_chk(string req, logic [11:0] q, int exp);
    peek_qnum = q; #1;
    chk(req, 32'(peek_count), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic        v;
    logic [31:0] a;
    do_reset();
    #1;
    // R10 reset state
    chk("R10 err", 32'(err_flag), 0);
    chk("R10 rsp_valid", 32'(pop_rsp_valid), 0);
    chk("R10 push_ready", 32'(push_ready), 1);
    chk("R10 nonempty", 32'(q_nonempty), 0);
    for (int q = 100; q < 104; q++) peek_chk("R10 count", 12'(q), 0);

    // vector table: R1 R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      if (!VEC[k].is_pop) begin
        do_push(VEC[k].q, VEC[k].arg);
        exp_cnt[VEC[k].q - 100]++;
        peek_chk("R1 push count", VEC[k].q, exp_cnt[VEC[k].q - 100]);
      end else begin
        do_pop(VEC[k].q, v, a);
        chk("R3 rsp valid", 32'(v), 1);
        chk("R3/R4 pop addr", a, VEC[k].arg);
        if (exp_cnt[VEC[k].q - 100] > 0) exp_cnt[VEC[k].q - 100]--;
        peek_chk("R3/R5 pop count", VEC[k].q, exp_cnt[VEC[k].q - 100]);
      end
    end
    chk("R2 no error on region edges", 32'(err_flag), 0);

    // R5 unowned pop
    do_pop(12'd104, v, a);
    chk("R5 unowned pop valid", 32'(v), 1);
    chk("R5 unowned pop addr", a, 0);

    // R8 peek of unowned number
    peek_qnum = 12'd50; #1;
    chk("R8 unowned peek count", 32'(peek_count), 0);
    chk("R8 unowned peek nonempty", 32'(peek_nonempty), 0);

    // R4 long list in one queue while another is live, R9 vector
    do_push(12'd103, 32'h2000_0100);
    for (int i = 0; i < 16; i++) do_push(12'd101, 32'h1000_0000 + 32'(i) * 32'h40);
    peek_chk("R4 fill count", 12'd101, 16);
    chk("R9 nonempty vector", 32'(q_nonempty), 32'b1010);
    peek_qnum = 12'd101; #1;
    chk("R8 peek nonempty", 32'(peek_nonempty), 1);
    for (int i = 0; i < 16; i++) begin
      do_pop(12'd101, v, a);
      chk("R4 drain order", a, 32'h1000_0000 + 32'(i) * 32'h40);
    end
    do_pop(12'd103, v, a);
    chk("R4 other queue intact", a, 32'h2000_0100);
    chk("R9 empty vector", 32'(q_nonempty), 0);

    // R7 same-queue collision
    @(negedge clk);
    push_valid = 1'b1; push_qnum = 12'd102; push_addr = 32'h2000_0200;
    pop_valid = 1'b1; pop_qnum = 12'd102;
    #1;
    chk("R7 pop_ready low", 32'(pop_ready), 0);
    @(posedge clk); #1;
    chk("R7 no rsp on stall", 32'(pop_rsp_valid), 0);
    peek_chk("R7 push first", 12'd102, 1);
    @(negedge clk);
    push_valid = 1'b0;
    #1;
    chk("R7 pop_ready high", 32'(pop_ready), 1);
    @(posedge clk); #1;
    pop_valid = 1'b0;
    chk("R7 held pop valid", 32'(pop_rsp_valid), 1);
    chk("R7 held pop addr", pop_rsp_addr, 32'h2000_0200);
    peek_chk("R7 count after", 12'd102, 0);

    // different queues in one cycle: no stall
    @(negedge clk);
    push_valid = 1'b1; push_qnum = 12'd102; push_addr = 32'h1000_0080;
    pop_valid = 1'b1; pop_qnum = 12'd103;
    #1;
    chk("R7 no stall other queue", 32'(pop_ready), 1);
    @(posedge clk); #1;
    push_valid = 1'b0; pop_valid = 1'b0;
    chk("R5 empty pop addr", pop_rsp_addr, 0);
    peek_chk("R1 concurrent push", 12'd102, 1);

    // R6 error causes, each from reset
    do_reset();
    do_push(12'd100, 32'h1000_0020);
    chk("R6 misaligned err", 32'(err_flag), 1);
    peek_chk("R6 misaligned dropped", 12'd100, 0);
    do_push(12'd100, 32'h1000_0040);
    chk("R6 sticky", 32'(err_flag), 1);
    peek_chk("R6 good push after err", 12'd100, 1);

    do_reset();
    do_push(12'd100, 32'h1000_0400);
    chk("R6 past region 0 err", 32'(err_flag), 1);
    peek_chk("R6 past region dropped", 12'd100, 0);

    do_reset();
    do_push(12'd100, 32'h0FFF_FFC0);
    chk("R6 below base err", 32'(err_flag), 1);

    do_reset();
    do_push(12'd100, 32'h2000_1000);
    chk("R6 past region 1 err", 32'(err_flag), 1);

    do_reset();
    do_push(12'd104, 32'h1000_0000);
    chk("R6 unowned queue err", 32'(err_flag), 1);
    chk("R6 unowned dropped", 32'(q_nonempty), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule